// File: doc/BRIEF.md
# Byte-Lane Store Steering Unit

This unit sits between a processor's store path and a 64-bit memory bus. It turns byte, halfword and word stores at any byte address into bus write cycles. The store data is copied onto every byte lane of the bus, and a per-lane select mask shows which lanes the target should update. Because of the copying, a narrow target can wire up only the lowest lanes. It then uses the low address bits or the mask to pick its register.

The unit works in one of two modes, chosen per store. In lane-select mode it issues one write cycle that carries the mask. In merge mode it serves memories that always write whole words: it reads the addressed word, replaces only the bytes being stored, and writes the full word back. The bus uses a simple request/acknowledge handshake. A store that is not aligned to its own size is refused with an error pulse and causes no bus activity.

Top module: `store_lane_steer`

## Requirements
- R1: After reset, st_ready_o is 1 and bus_req_o, st_done_o and st_err_o are all 0.
- R2: The size code is 0 for byte, 1 for halfword, 2 for word and 3 for reserved. Lanes are little-endian: byte offset k within the 8-byte word is bus bits 8k+7:8k. A byte store has a select mask of 1 shifted left by addr[2:0].
- R3: A halfword store with addr[0]=0 has a select mask of 2'b11 shifted left by addr[2:1]*2.
- R4: A word store with addr[1:0]=0 has a select mask of 4'hF shifted left by addr[2]*4.
- R5: In lane-select mode, bus_wdata_o holds the store byte repeated 8 times, the halfword (bits 15:0) repeated 4 times, or the word repeated twice.
- R6: A store is refused if it is a halfword with addr[0]=1, a word with addr[1:0]≠0, or has size code 3. A refused store raises st_err_o for one cycle, starting the cycle after acceptance, and issues no bus request.
- R7: In lane-select mode (use_rmw_i=0), a store causes exactly one bus cycle, which is a write. st_done_o pulses for one cycle, the cycle after the write is acknowledged.
- R8: In merge mode (use_rmw_i=1), the unit first issues a read (bus_we_o=0, select all ones). In the cycle after the read is acknowledged, it requests a write with select all ones. The write data is the word that was read, with only the addressed bytes replaced.
- R9: st_ready_o is 0 from the cycle after a store is accepted until that store completes. Any store offered during that time is not taken.
- R10: bus_addr_o is the store address with bits 2:0 cleared. bus_addr_o and bus_we_o hold steady while a request waits for its acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| st_valid_i | input | 1 | Store request |
| st_ready_o | output | 1 | Unit can take a store |
| st_addr_i | input | ADDR_W | Byte address of the store |
| st_size_i | input | 2 | Size code: 0 byte, 1 halfword, 2 word |
| st_data_i | input | 32 | Store data, right-justified |
| use_rmw_i | input | 1 | 1 selects merge mode for this store |
| st_done_o | output | 1 | One-cycle pulse when the store completes |
| st_err_o | output | 1 | One-cycle pulse when a store is refused |
| bus_req_o | output | 1 | Bus request |
| bus_we_o | output | 1 | 1 for a write, 0 for a read |
| bus_addr_o | output | ADDR_W | Word-aligned bus address |
| bus_sel_o | output | LANES | Per-lane select |
| bus_wdata_o | output | 8*LANES | Write data |
| bus_ack_i | input | 1 | Bus acknowledge |
| bus_rdata_i | input | 8*LANES | Read data, valid with the acknowledge |

## Verification
A wrong captured mask or wrong replicated data shows up on bus_sel_o and bus_wdata_o during the first cycle of the request. It also leaves a corrupted word in the target, which the bench compares against its own model after every store. A sequencer stuck in the wrong state or taking a wrong branch shows up within a few cycles, as one of four symptoms: a missing or extra bus cycle, a read that is never followed by a write, a done or error pulse that never comes, or st_ready_o staying low.

// File: rtl/store_steer_pkg.sv
package store_steer_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } st_size_e;

  typedef enum logic [1:0] {
    S_IDLE,
    S_WRITE,
    S_READ,
    S_MERGE_WR
  } steer_state_e;
endpackage

// File: rtl/lane_mask_gen.sv
module lane_mask_gen
  import store_steer_pkg::*;
#(
  parameter int LANES = 8,
  localparam int OFF_W = $clog2(LANES)
) (
  input  logic [OFF_W-1:0] off_i,
  input  st_size_e         size_i,
  output logic [LANES-1:0] sel_o,
  output logic             misaligned_o
);
  logic [LANES-1:0] base;

  always_comb begin
    base         = '0;
    misaligned_o = 1'b0;
    unique case (size_i)
      SZ_BYTE: base = LANES'(4'h1);
      SZ_HALF: begin
        base         = LANES'(4'h3);
        misaligned_o = off_i[0];
      end
      SZ_WORD: begin
        base         = LANES'(4'hF);
        misaligned_o = |off_i[1:0];
      end
      default: misaligned_o = 1'b1;
    endcase
    sel_o = base << off_i;
  end
endmodule

// File: rtl/lane_replicate.sv
module lane_replicate
  import store_steer_pkg::*;
#(
  parameter int LANES = 8
) (
  input  logic [31:0]        data_i,
  input  st_size_e           size_i,
  output logic [LANES*8-1:0] wdata_o
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    always_comb begin
      unique case (size_i)
        SZ_BYTE: wdata_o[l*8 +: 8] = data_i[7:0];
        SZ_HALF: wdata_o[l*8 +: 8] = data_i[(l % 2)*8 +: 8];
        default: wdata_o[l*8 +: 8] = data_i[(l % 4)*8 +: 8];
      endcase
    end
  end
endmodule

// File: rtl/lane_merge.sv
module lane_merge #(
  parameter int LANES = 8
) (
  input  logic [LANES*8-1:0] old_i,
  input  logic [LANES*8-1:0] new_i,
  input  logic [LANES-1:0]   sel_i,
  output logic [LANES*8-1:0] merged_o
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign merged_o[l*8 +: 8] = sel_i[l] ? new_i[l*8 +: 8] : old_i[l*8 +: 8];
  end
endmodule

// File: rtl/store_lane_steer.sv
module store_lane_steer
  import store_steer_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LANES  = 8,
  localparam int BUS_W = LANES * 8,
  localparam int OFF_W = $clog2(LANES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              st_valid_i,
  output logic              st_ready_o,
  input  logic [ADDR_W-1:0] st_addr_i,
  input  logic [1:0]        st_size_i,
  input  logic [31:0]       st_data_i,
  input  logic              use_rmw_i,
  output logic              st_done_o,
  output logic              st_err_o,
  output logic              bus_req_o,
  output logic              bus_we_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [LANES-1:0]  bus_sel_o,
  output logic [BUS_W-1:0]  bus_wdata_o,
  input  logic              bus_ack_i,
  input  logic [BUS_W-1:0]  bus_rdata_i
);
  steer_state_e      state_q;
  logic [ADDR_W-1:0] addr_q;
  logic [LANES-1:0]  sel_q;
  logic [BUS_W-1:0]  wdata_q, merged_q;
  logic              done_q, err_q;

  logic [LANES-1:0]  sel_d;
  logic              misaligned;
  logic [BUS_W-1:0]  rep_d, merged_d;
  st_size_e          size;
  logic              accept;

  assign size   = st_size_e'(st_size_i);
  assign accept = st_valid_i && (state_q == S_IDLE);

  lane_mask_gen #(.LANES(LANES)) i_mask (
    .off_i       (st_addr_i[OFF_W-1:0]),
    .size_i      (size),
    .sel_o       (sel_d),
    .misaligned_o(misaligned)
  );

  lane_replicate #(.LANES(LANES)) i_rep (
    .data_i (st_data_i),
    .size_i (size),
    .wdata_o(rep_d)
  );

  lane_merge #(.LANES(LANES)) i_merge (
    .old_i   (bus_rdata_i),
    .new_i   (wdata_q),
    .sel_i   (sel_q),
    .merged_o(merged_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= S_IDLE;
      addr_q   <= '0;
      sel_q    <= '0;
      wdata_q  <= '0;
      merged_q <= '0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      unique case (state_q)
        S_IDLE: if (accept) begin
          if (misaligned) begin
            err_q <= 1'b1;
          end else begin
            addr_q  <= {st_addr_i[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
            sel_q   <= sel_d;
            wdata_q <= rep_d;
            state_q <= use_rmw_i ? S_READ : S_WRITE;
          end
        end
        S_READ: if (bus_ack_i) begin
          merged_q <= merged_d;
          state_q  <= S_MERGE_WR;
        end
        default: if (bus_ack_i) begin
          done_q  <= 1'b1;
          state_q <= S_IDLE;
        end
      endcase
    end
  end

  assign st_ready_o  = (state_q == S_IDLE);
  assign st_done_o   = done_q;
  assign st_err_o    = err_q;
  assign bus_req_o   = (state_q != S_IDLE);
  assign bus_we_o    = (state_q == S_WRITE) || (state_q == S_MERGE_WR);
  assign bus_addr_o  = addr_q;
  assign bus_sel_o   = (state_q == S_WRITE) ? sel_q : '1;
  assign bus_wdata_o = (state_q == S_MERGE_WR) ? merged_q : wdata_q;
endmodule

// File: rtl/store_lane_steer_chk.sv
module store_lane_steer_chk #(
  parameter int ADDR_W = 32,
  parameter int LANES  = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              st_ready_o,
  input logic              st_done_o,
  input logic              st_err_o,
  input logic              bus_req_o,
  input logic              bus_we_o,
  input logic [ADDR_W-1:0] bus_addr_o,
  input logic [LANES-1:0]  bus_sel_o,
  input logic              bus_ack_i
);
  p_addr_aligned_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o |-> (bus_addr_o[2:0] == 3'b000));

  p_req_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && !bus_ack_i) |=> (bus_req_o && $stable(bus_addr_o) && $stable(bus_we_o)));

  p_err_no_req_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_err_o |-> (!bus_req_o && !$past(bus_req_o)));

  p_done_after_ack_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_done_o |-> $past(bus_req_o && bus_we_o && bus_ack_i));

  p_rmw_b2b_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && !bus_we_o && bus_ack_i) |=> (bus_req_o && bus_we_o));

  p_read_full_sel_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && !bus_we_o) |-> (bus_sel_o == '1));

  p_busy_not_ready_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o |-> !st_ready_o);

  p_sel_nonzero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o |-> (bus_sel_o != '0));
endmodule

bind store_lane_steer store_lane_steer_chk #(.ADDR_W(ADDR_W), .LANES(LANES)) i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .st_ready_o(st_ready_o),
  .st_done_o (st_done_o),
  .st_err_o  (st_err_o),
  .bus_req_o (bus_req_o),
  .bus_we_o  (bus_we_o),
  .bus_addr_o(bus_addr_o),
  .bus_sel_o (bus_sel_o),
  .bus_ack_i (bus_ack_i)
);

// File: tb/test_store_lane_steer.sv
module test_store_lane_steer;
  localparam int ADDR_W = 32;
  localparam int LANES  = 8;
  localparam int BUS_W  = 64;
  localparam int NV     = 14;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              st_valid_i = 1'b0;
  logic              st_ready_o;
  logic [ADDR_W-1:0] st_addr_i = '0;
  logic [1:0]        st_size_i = '0;
  logic [31:0]       st_data_i = '0;
  logic              use_rmw_i = 1'b0;
  logic              st_done_o, st_err_o;
  logic              bus_req_o, bus_we_o;
  logic [ADDR_W-1:0] bus_addr_o;
  logic [LANES-1:0]  bus_sel_o;
  logic [BUS_W-1:0]  bus_wdata_o;
  logic              bus_ack_i;
  logic [BUS_W-1:0]  bus_rdata_i;

  always #5 clk_i = ~clk_i;

  store_lane_steer #(.ADDR_W(ADDR_W), .LANES(LANES)) i_store_lane_steer (
    .clk_i, .rst_ni, .st_valid_i, .st_ready_o, .st_addr_i, .st_size_i,
    .st_data_i, .use_rmw_i, .st_done_o, .st_err_o, .bus_req_o, .bus_we_o,
    .bus_addr_o, .bus_sel_o, .bus_wdata_o, .bus_ack_i, .bus_rdata_i
  );

  // target: 4 words, ack every other cycle, honours the select mask
  logic [BUS_W-1:0] mem [4];
  logic [BUS_W-1:0] ref_mem [4];
  int cyc = 0, wr_cnt = 0, rd_cnt = 0, wr_cyc = 0, rd_cyc = 0;
  logic [LANES-1:0]  last_sel;
  logic [BUS_W-1:0]  last_wdata;
  logic [ADDR_W-1:0] last_addr;

  function automatic logic [BUS_W-1:0] init_word(int i);
    return 64'h0011_2233_4455_6677 ^ {8{8'(i * 17 + 1)}};
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bus_ack_i   <= 1'b0;
      bus_rdata_i <= '0;
      for (int i = 0; i < 4; i++) mem[i] <= init_word(i);
    end else begin
      bus_ack_i   <= bus_req_o && !bus_ack_i;
      bus_rdata_i <= mem[bus_addr_o[4:3]];
      if (bus_req_o && !bus_ack_i && bus_we_o)
        for (int b = 0; b < LANES; b++)
          if (bus_sel_o[b]) mem[bus_addr_o[4:3]][b*8 +: 8] <= bus_wdata_o[b*8 +: 8];
    end
  end

  always @(posedge clk_i) begin
    cyc <= cyc + 1;
    if (rst_ni && bus_req_o && bus_ack_i) begin
      if (bus_we_o) begin
        wr_cnt     <= wr_cnt + 1;
        wr_cyc     <= cyc;
        last_sel   <= bus_sel_o;
        last_wdata <= bus_wdata_o;
        last_addr  <= bus_addr_o;
      end else begin
        rd_cnt <= rd_cnt + 1;
        rd_cyc <= cyc;
      end
    end
  end

  int n_chk = 0, n_fail = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [BUS_W-1:0] rep(logic [1:0] sz, logic [31:0] d);
    case (sz)
      2'd0:    return {8{d[7:0]}};
      2'd1:    return {4{d[15:0]}};
      default: return {2{d}};
    endcase
  endfunction

  // {rmw, size[1:0], addr[5:0], data[31:0], exp_err, exp_sel[7:0]}
  localparam logic [49:0] VEC [NV] = '{
    {1'b0, 2'd0, 6'h00, 32'h0000_00A5, 1'b0, 8'h01},
    {1'b0, 2'd0, 6'h05, 32'h0000_003C, 1'b0, 8'h20},
    {1'b0, 2'd0, 6'h0F, 32'hFFFF_FF7E, 1'b0, 8'h80},
    {1'b0, 2'd1, 6'h02, 32'h0000_BEEF, 1'b0, 8'h0C},
    {1'b0, 2'd1, 6'h16, 32'h1234_C0DE, 1'b0, 8'hC0},
    {1'b0, 2'd2, 6'h10, 32'hDEAD_BEEF, 1'b0, 8'h0F},
    {1'b0, 2'd2, 6'h1C, 32'hCAFE_F00D, 1'b0, 8'hF0},
    {1'b0, 2'd1, 6'h03, 32'h0000_1111, 1'b1, 8'h00},
    {1'b0, 2'd2, 6'h06, 32'h2222_2222, 1'b1, 8'h00},
    {1'b0, 2'd3, 6'h00, 32'h3333_3333, 1'b1, 8'h00},
    {1'b1, 2'd0, 6'h09, 32'h0000_005A, 1'b0, 8'h02},
    {1'b1, 2'd1, 6'h14, 32'h0000_A55A, 1'b0, 8'h30},
    {1'b1, 2'd2, 6'h18, 32'h0BAD_F00D, 1'b0, 8'h0F},
    {1'b1, 2'd2, 6'h02, 32'h4444_4444, 1'b1, 8'h00}
  };

  initial begin
    repeat (20000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog expired act=%0d exp=%0d", cyc, 20000);
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) ref_mem[i] = init_word(i);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset state
    chk(st_ready_o === 1'b1, "R1 ready", 64'(st_ready_o), 64'd1);
    chk(bus_req_o === 1'b0 && st_done_o === 1'b0 && st_err_o === 1'b0, "R1 idle outputs",
        64'({bus_req_o, st_done_o, st_err_o}), 64'd0);

    for (int v = 0; v < NV; v++) begin
      logic        rmw, eerr;
      logic [1:0]  sz;
      logic [5:0]  a;
      logic [31:0] d;
      logic [7:0]  esel;
      int          wr0, rd0, w;
      string       mtag;
      {rmw, sz, a, d, eerr, esel} = VEC[v];
      mtag = (sz == 2'd0) ? "R2 byte sel" : (sz == 2'd1) ? "R3 half sel" : "R4 word sel";
      wr0 = wr_cnt;
      rd0 = rd_cnt;
      st_valid_i = 1'b1;
      st_addr_i  = ADDR_W'(a);
      st_size_i  = sz;
      st_data_i  = d;
      use_rmw_i  = rmw;
      @(negedge clk_i);
      st_valid_i = 1'b0;
      if (!eerr) chk(st_ready_o === 1'b0, "R9 busy after accept", 64'(st_ready_o), 64'd0);
      for (w = 0; w < 20; w++) begin
        if (st_done_o || st_err_o) break;
        @(negedge clk_i);
      end
      chk(st_err_o === eerr, "R6 error flag", 64'(st_err_o), 64'(eerr));
      if (eerr) begin
        repeat (3) @(negedge clk_i);
        chk(wr_cnt == wr0 && rd_cnt == rd0, "R6 no bus cycle", 64'(wr_cnt + rd_cnt), 64'(wr0 + rd0));
      end else begin
        chk(st_done_o === 1'b1, "R7 done pulse", 64'(st_done_o), 64'd1);
        chk(wr_cnt - wr0 == 1, "R7 one write", 64'(wr_cnt - wr0), 64'd1);
        chk(rd_cnt - rd0 == int'(rmw), "R8 read count", 64'(rd_cnt - rd0), 64'(rmw));
        chk(last_addr == {26'd0, a[5:3], 3'b000}, "R10 bus addr", 64'(last_addr), 64'({a[5:3], 3'b000}));
        for (int b = 0; b < LANES; b++)
          if (esel[b]) ref_mem[a[4:3]][b*8 +: 8] = rep(sz, d)[b*8 +: 8];
        if (rmw) begin
          chk(last_sel == 8'hFF, "R8 full sel", 64'(last_sel), 64'hFF);
          chk(wr_cyc - rd_cyc == 2, "R8 write follows read", 64'(wr_cyc - rd_cyc), 64'd2);
          chk(last_wdata == ref_mem[a[4:3]], "R8 merged data", last_wdata, ref_mem[a[4:3]]);
        end else begin
          chk(last_sel == esel, mtag, 64'(last_sel), 64'(esel));
          chk(last_wdata == rep(sz, d), "R5 replicated data", last_wdata, rep(sz, d));
        end
        chk(mem[a[4:3]] == ref_mem[a[4:3]], "R8 target word", mem[a[4:3]], ref_mem[a[4:3]]);
        @(negedge clk_i);
        chk(st_done_o === 1'b0, "R7 done one cycle", 64'(st_done_o), 64'd0);
      end
    end

    // R9: a store held on the port while busy is not taken a second time
    begin
      int wr0, w;
      wr0 = wr_cnt;
      st_valid_i = 1'b1;
      st_addr_i  = 32'h0000_0008;
      st_size_i  = 2'd0;
      st_data_i  = 32'h0000_0099;
      use_rmw_i  = 1'b1;
      for (w = 0; w < 20; w++) begin
        @(negedge clk_i);
        if (st_done_o) break;
      end
      st_valid_i = 1'b0;
      repeat (4) @(negedge clk_i);
      chk(wr_cnt - wr0 == 1, "R9 held store taken once", 64'(wr_cnt - wr0), 64'd1);
      chk(st_ready_o === 1'b1, "R9 ready again", 64'(st_ready_o), 64'd1);
      ref_mem[1][7:0] = 8'h99;
      chk(mem[1] == ref_mem[1], "R8 held store merged", mem[1], ref_mem[1]);
    end

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule